// File: doc/BRIEF.md
# Hermitian Sample Covariance Engine

This block turns a matrix of complex array snapshots, one row per sensor and one column per snapshot, into its unnormalised sample covariance matrix. Software or an upstream mover writes the samples through a linear-index port, starts the engine, waits for the done pulse and then reads any covariance entry by its row and column. Scaling by the snapshot count is left to the consumer, which only needs a shift or a constant multiply on the read data.

Only the entries on and below the diagonal are ever computed. Each is the complex dot product of one row with the conjugate of another, built by a single multiply-accumulate unit at one sample pair per clock. The entries are kept in a small set of result banks in column-major lower-triangle order. A read above the diagonal fetches the mirrored entry and negates its imaginary part, so the upper half costs no cycles and no storage. Samples live in banked memory, and the bank and in-bank address come from a fixed modulo and divide map on the sample index.

Top module: `cov_engine`

## Requirements
- R1: While reset is held, `busy` and `done` are 0 and `rdRe`/`rdIm` are 0.
- R2: A write with `wrIndex` = n < ROWS·NCOL stores the sample as row n / NCOL, column n mod NCOL: source bank (column mod SRC_BANKS), in-bank address (column / SRC_BANKS)·ROWS + row. A write with n ≥ ROWS·NCOL is ignored and leaves every result unchanged.
- R3: For row a ≥ column b, the entry equals Σk x[a][k]·conj(x[b][k]) over all NCOL snapshots. Real and imaginary parts are each held in ACC_W = 2·SW+1+log2(NCOL) signed bits, with no overflow even when every sample is at full scale.
- R4: For row a < column b, the read data is the conjugate of entry (b,a): the same real part and a negated imaginary part.
- R5: `rdRe`/`rdIm` show the entry addressed by `rdRow`/`rdCol` at the previous rising edge, a latency of one cycle.
- R6: One multiply-accumulate is issued per cycle. `done` rises exactly ROWS·(ROWS+1)/2·NCOL + 1 cycles after the edge that samples `start` while idle.
- R7: `busy` rises the cycle after an accepted `start` and stays high through the single-cycle `done` pulse. It falls the cycle after `done`.
- R8: `start` while `busy` is high is ignored. The run keeps its timing and produces exactly one `done`.
- R9: Every diagonal entry has a zero imaginary part and a non-negative real part.
- R10: Each accepted `start` clears the sums, so results reflect only the samples present for that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Sample write strobe |
| wrIndex | input | log2(ROWS·NCOL)+1 | Linear sample index, row-major |
| wrRe | input | SW | Sample real part, signed |
| wrIm | input | SW | Sample imaginary part, signed |
| start | input | 1 | Begin a covariance run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when all lower entries are stored |
| rdRow | input | log2(ROWS) | Read row |
| rdCol | input | log2(ROWS) | Read column |
| rdRe | output | ACC_W | Entry real part, signed |
| rdIm | output | ACC_W | Entry imaginary part, signed |

## Verification
On every cycle the assertions check the handshake: `done` is a single-cycle pulse inside `busy`, an idle `start` raises `busy`, a `start` during a run does not stop it, and every diagonal result written has a zero imaginary part and a non-negative real part. Only the bench scenarios can show the arithmetic. They cover the sample address map, the value of every entry above and below the diagonal under ramp, full-scale and pseudo-random data, the exact run length, the rejection of an out-of-range write, and the clearing of sums between runs.

// File: rtl/cov_pkg.sv
package cov_pkg;

  // Per-issue strobes handed from control to datapath
  typedef struct packed {
    logic valid;  // a sample pair is being fetched this cycle
    logic first;  // first snapshot of an entry: restart the sum
    logic last;   // last snapshot of an entry: store the sum
    logic fin;    // last snapshot of the last entry
    logic diag;   // entry lies on the diagonal
  } covStrobe_t;

  // Position of column lo's first entry in column-major lower-triangle order
  function automatic int triOffset(int lo, int rows);
    return (lo * (2 * rows - lo + 1)) / 2;
  endfunction

endpackage

// File: rtl/cov_sample_store.sv
module cov_sample_store #(
  parameter int ROWS      = 8,
  parameter int NCOL      = 128,
  parameter int SW        = 16,
  parameter int SRC_BANKS = 13
) (
  input  logic                                   clk,
  input  logic                                   wrEn,
  input  logic [$clog2(ROWS*NCOL):0]             wrIndex,
  input  logic signed [SW-1:0]                   wrRe,
  input  logic signed [SW-1:0]                   wrIm,
  input  logic [(NCOL > 1 ? $clog2(NCOL) : 1)-1:0] rdK,
  input  logic [(ROWS > 1 ? $clog2(ROWS) : 1)-1:0] rdRowA,
  input  logic [(ROWS > 1 ? $clog2(ROWS) : 1)-1:0] rdRowB,
  output logic signed [SW-1:0]                   aRe,
  output logic signed [SW-1:0]                   aIm,
  output logic signed [SW-1:0]                   bRe,
  output logic signed [SW-1:0]                   bIm
);
  localparam int TOTAL = ROWS * NCOL;
  localparam int ZONES = (NCOL + SRC_BANKS - 1) / SRC_BANKS;
  localparam int DEPTH = ZONES * ROWS;
  localparam int AW    = DEPTH > 1 ? $clog2(DEPTH) : 1;
  localparam int BW    = SRC_BANKS > 1 ? $clog2(SRC_BANKS) : 1;
  localparam int DW    = 2 * SW;

  logic          wInRange;
  logic [BW-1:0] wBank;
  logic [AW-1:0] wAddr;
  logic [BW-1:0] rBank;
  logic [AW-1:0] rAddrA;
  logic [AW-1:0] rAddrB;
  logic [SRC_BANKS-1:0][DW-1:0] bankA;
  logic [SRC_BANKS-1:0][DW-1:0] bankB;
  logic [DW-1:0] wordA;
  logic [DW-1:0] wordB;

  // Write side: linear index -> (row, column) -> (bank, zone address)
  always_comb begin
    int n;
    int wRow;
    int wCol;
    n        = int'(wrIndex);
    wInRange = (n < TOTAL);
    wRow     = n / NCOL;
    wCol     = n % NCOL;
    wBank    = BW'(wCol % SRC_BANKS);
    wAddr    = AW'((wCol / SRC_BANKS) * ROWS + wRow);
  end

  // Read side: snapshot k picks the bank and zone, the row picks the slot
  always_comb begin
    int k;
    k      = int'(rdK);
    rBank  = BW'(k % SRC_BANKS);
    rAddrA = AW'((k / SRC_BANKS) * ROWS + int'(rdRowA));
    rAddrB = AW'((k / SRC_BANKS) * ROWS + int'(rdRowB));
  end

  for (genvar g = 0; g < SRC_BANKS; g++) begin : gBank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wrEn && wInRange && (wBank == BW'(g)))
        mem[wAddr] <= {wrRe, wrIm};
    end
    assign bankA[g] = mem[rAddrA];
    assign bankB[g] = mem[rAddrB];
  end

  always_ff @(posedge clk) begin
    wordA <= bankA[rBank];
    wordB <= bankB[rBank];
  end

  assign aRe = wordA[DW-1:SW];
  assign aIm = wordA[SW-1:0];
  assign bRe = wordB[DW-1:SW];
  assign bIm = wordB[SW-1:0];

endmodule

// File: rtl/cov_ctrl.sv
module cov_ctrl
  import cov_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int NCOL = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic doneIn,
  output logic busy,
  output covStrobe_t strobe,
  output logic [((ROWS*(ROWS+1))/2 > 1 ? $clog2((ROWS*(ROWS+1))/2) : 1)-1:0] resIdx,
  output logic [(NCOL > 1 ? $clog2(NCOL) : 1)-1:0] kIdx,
  output logic [(ROWS > 1 ? $clog2(ROWS) : 1)-1:0] rowA,
  output logic [(ROWS > 1 ? $clog2(ROWS) : 1)-1:0] rowB
);
  localparam int TRI = (ROWS * (ROWS + 1)) / 2;
  localparam int TW  = TRI > 1 ? $clog2(TRI) : 1;
  localparam int KW  = NCOL > 1 ? $clog2(NCOL) : 1;
  localparam int RW  = ROWS > 1 ? $clog2(ROWS) : 1;
  localparam logic [KW-1:0] KLAST = KW'(NCOL - 1);
  localparam logic [RW-1:0] RLAST = RW'(ROWS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} state_t;

  state_t        state;
  logic [KW-1:0] kQ;
  logic [RW-1:0] aQ;
  logic [RW-1:0] bQ;
  logic [TW-1:0] resIdxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kQ      <= '0;
      aQ      <= '0;
      bQ      <= '0;
      resIdxQ <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_RUN;
            kQ      <= '0;
            aQ      <= '0;
            bQ      <= '0;
            resIdxQ <= '0;
          end
        end
        S_RUN: begin
          if (kQ == KLAST) begin
            kQ      <= '0;
            resIdxQ <= resIdxQ + 1'b1;
            if (aQ == RLAST) begin
              if (bQ == RLAST) begin
                state <= S_WAIT;
              end else begin
                bQ <= bQ + 1'b1;
                aQ <= bQ + 1'b1;
              end
            end else begin
              aQ <= aQ + 1'b1;
            end
          end else begin
            kQ <= kQ + 1'b1;
          end
        end
        S_WAIT: begin
          if (doneIn) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.valid = (state == S_RUN);
    strobe.first = (kQ == '0);
    strobe.last  = (kQ == KLAST);
    strobe.fin   = (kQ == KLAST) && (bQ == RLAST);
    strobe.diag  = (aQ == bQ);
  end

  assign busy   = (state != S_IDLE);
  assign resIdx = resIdxQ;
  assign kIdx   = kQ;
  assign rowA   = aQ;
  assign rowB   = bQ;

endmodule

// File: rtl/cov_datapath.sv
module cov_datapath
  import cov_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int NCOL      = 128,
  parameter int SW        = 16,
  parameter int RES_DEPTH = 16
) (
  input  logic clk,
  input  logic rstN,
  input  covStrobe_t strobe,
  input  logic [((ROWS*(ROWS+1))/2 > 1 ? $clog2((ROWS*(ROWS+1))/2) : 1)-1:0] resIdxIn,
  input  logic signed [SW-1:0] aRe,
  input  logic signed [SW-1:0] aIm,
  input  logic signed [SW-1:0] bRe,
  input  logic signed [SW-1:0] bIm,
  input  logic [(ROWS > 1 ? $clog2(ROWS) : 1)-1:0] rdRow,
  input  logic [(ROWS > 1 ? $clog2(ROWS) : 1)-1:0] rdCol,
  output logic done,
  output logic signed [2*SW+1+(NCOL > 1 ? $clog2(NCOL) : 1)-1:0] rdRe,
  output logic signed [2*SW+1+(NCOL > 1 ? $clog2(NCOL) : 1)-1:0] rdIm,
  output logic resWe,
  output logic resDiag,
  output logic signed [2*SW+1+(NCOL > 1 ? $clog2(NCOL) : 1)-1:0] resRe,
  output logic signed [2*SW+1+(NCOL > 1 ? $clog2(NCOL) : 1)-1:0] resIm
);
  localparam int TRI       = (ROWS * (ROWS + 1)) / 2;
  localparam int TW        = TRI > 1 ? $clog2(TRI) : 1;
  localparam int ACC_W     = 2 * SW + 1 + (NCOL > 1 ? $clog2(NCOL) : 1);
  localparam int PW        = 2 * SW + 1;
  localparam int RES_BANKS = (TRI + RES_DEPTH - 1) / RES_DEPTH;
  localparam int RBW       = RES_BANKS > 1 ? $clog2(RES_BANKS) : 1;
  localparam int RAW       = RES_DEPTH > 1 ? $clog2(RES_DEPTH) : 1;

  covStrobe_t            stQ;
  logic [TW-1:0]         idxQ;
  logic signed [2*SW-1:0] mRr, mIi, mIr, mRi;
  logic signed [PW-1:0]  prodRe, prodIm;
  logic signed [ACC_W-1:0] accRe, accIm;
  logic signed [ACC_W-1:0] sumRe, sumIm;
  logic [RBW-1:0]        wBank;
  logic [RAW-1:0]        wAddr;
  logic [RBW-1:0]        rBank;
  logic [RAW-1:0]        rAddr;
  logic                  rMirror;
  logic [RES_BANKS-1:0][2*ACC_W-1:0] bankOut;
  logic [2*ACC_W-1:0]    rdWordQ;
  logic                  mirrorQ;

  // Strobes line up with the registered sample read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ  <= '0;
      idxQ <= '0;
    end else begin
      stQ  <= strobe;
      idxQ <= resIdxIn;
    end
  end

  // x[a] * conj(x[b])
  always_comb begin
    mRr    = aRe * bRe;
    mIi    = aIm * bIm;
    mIr    = aIm * bRe;
    mRi    = aRe * bIm;
    prodRe = PW'(mRr) + PW'(mIi);
    prodIm = PW'(mIr) - PW'(mRi);
    sumRe  = (stQ.first ? '0 : accRe) + ACC_W'(prodRe);
    sumIm  = (stQ.first ? '0 : accIm) + ACC_W'(prodIm);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accRe <= '0;
      accIm <= '0;
      done  <= 1'b0;
    end else begin
      if (stQ.valid) begin
        accRe <= sumRe;
        accIm <= sumIm;
      end
      done <= stQ.valid && stQ.fin;
    end
  end

  assign resWe   = stQ.valid && stQ.last;
  assign resDiag = stQ.diag;
  assign resRe   = sumRe;
  assign resIm   = sumIm;

  always_comb begin
    wBank = RBW'(int'(idxQ) / RES_DEPTH);
    wAddr = RAW'(int'(idxQ) % RES_DEPTH);
  end

  // Read address: upper entries fold onto their lower mirror
  always_comb begin
    int hi;
    int lo;
    int idx;
    rMirror = (rdRow < rdCol);
    hi      = rMirror ? int'(rdCol) : int'(rdRow);
    lo      = rMirror ? int'(rdRow) : int'(rdCol);
    idx     = triOffset(lo, ROWS) + hi - lo;
    rBank   = RBW'(idx / RES_DEPTH);
    rAddr   = RAW'(idx % RES_DEPTH);
  end

  for (genvar g = 0; g < RES_BANKS; g++) begin : gRes
    logic [2*ACC_W-1:0] mem [RES_DEPTH];
    always_ff @(posedge clk) begin
      if (resWe && (wBank == RBW'(g)))
        mem[wAddr] <= {sumRe, sumIm};
    end
    assign bankOut[g] = mem[rAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdWordQ <= '0;
      mirrorQ <= 1'b0;
    end else begin
      rdWordQ <= bankOut[rBank];
      mirrorQ <= rMirror;
    end
  end

  always_comb begin
    rdRe = rdWordQ[2*ACC_W-1:ACC_W];
    rdIm = mirrorQ ? -$signed(rdWordQ[ACC_W-1:0]) : $signed(rdWordQ[ACC_W-1:0]);
  end

endmodule

// File: rtl/cov_engine.sv
module cov_engine
  import cov_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int NCOL      = 128,
  parameter int SW        = 16,
  parameter int NBANKS    = 16,
  parameter int RES_DEPTH = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [$clog2(ROWS*NCOL):0] wrIndex,
  input  logic signed [SW-1:0] wrRe,
  input  logic signed [SW-1:0] wrIm,
  input  logic start,
  output logic busy,
  output logic done,
  input  logic [(ROWS > 1 ? $clog2(ROWS) : 1)-1:0] rdRow,
  input  logic [(ROWS > 1 ? $clog2(ROWS) : 1)-1:0] rdCol,
  output logic signed [2*SW+1+(NCOL > 1 ? $clog2(NCOL) : 1)-1:0] rdRe,
  output logic signed [2*SW+1+(NCOL > 1 ? $clog2(NCOL) : 1)-1:0] rdIm
);
  localparam int TRI       = (ROWS * (ROWS + 1)) / 2;
  localparam int TW        = TRI > 1 ? $clog2(TRI) : 1;
  localparam int KW        = NCOL > 1 ? $clog2(NCOL) : 1;
  localparam int RW        = ROWS > 1 ? $clog2(ROWS) : 1;
  localparam int ACC_W     = 2 * SW + 1 + KW;
  localparam int RES_BANKS = (TRI + RES_DEPTH - 1) / RES_DEPTH;
  localparam int SRC_BANKS = NBANKS - RES_BANKS;

  covStrobe_t strobe;
  logic [TW-1:0] resIdx;
  logic [KW-1:0] kIdx;
  logic [RW-1:0] rowA, rowB;
  logic signed [SW-1:0] aRe, aIm, bRe, bIm;
  logic resWe, resDiag;
  logic signed [ACC_W-1:0] resRe, resIm;

  cov_ctrl #(.ROWS(ROWS), .NCOL(NCOL)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .doneIn(done), .busy(busy),
    .strobe(strobe), .resIdx(resIdx), .kIdx(kIdx), .rowA(rowA), .rowB(rowB)
  );

  cov_sample_store #(.ROWS(ROWS), .NCOL(NCOL), .SW(SW), .SRC_BANKS(SRC_BANKS)) uStore (
    .clk(clk), .wrEn(wrEn), .wrIndex(wrIndex), .wrRe(wrRe), .wrIm(wrIm),
    .rdK(kIdx), .rdRowA(rowA), .rdRowB(rowB),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm)
  );

  cov_datapath #(.ROWS(ROWS), .NCOL(NCOL), .SW(SW), .RES_DEPTH(RES_DEPTH)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .resIdxIn(resIdx),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .rdRow(rdRow), .rdCol(rdCol), .done(done), .rdRe(rdRe), .rdIm(rdIm),
    .resWe(resWe), .resDiag(resDiag), .resRe(resRe), .resIm(resIm)
  );

endmodule

// File: rtl/cov_engine_chk.sv
module cov_engine_chk #(
  parameter int ACC_W = 40
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic resWe,
  input logic resDiag,
  input logic signed [ACC_W-1:0] resRe,
  input logic signed [ACC_W-1:0] resIm
);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_start_launch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && !done) |=> busy);

  p_write_in_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    resWe |-> busy);

  p_diag_real_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && resDiag) |-> (resIm == '0 && !resRe[ACC_W-1]));

endmodule

bind cov_engine cov_engine_chk #(.ACC_W(ACC_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .resWe(resWe), .resDiag(resDiag), .resRe(resRe), .resIm(resIm)
);

// File: tb/cov_engine_test.sv
module cov_engine_test;
  localparam int ROWS  = 8;
  localparam int NCOL  = 128;
  localparam int SW    = 16;
  localparam int TOTAL = ROWS * NCOL;
  localparam int TRI   = (ROWS * (ROWS + 1)) / 2;
  localparam int ACC_W = 2 * SW + 1 + $clog2(NCOL);
  localparam int IW    = $clog2(TOTAL) + 1;
  localparam int RW    = $clog2(ROWS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [IW-1:0] wrIndex = '0;
  logic signed [SW-1:0] wrRe = '0, wrIm = '0;
  logic start = 1'b0;
  logic busy, done;
  logic [RW-1:0] rdRow = '0, rdCol = '0;
  logic signed [ACC_W-1:0] rdRe, rdIm;

  cov_engine uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIndex(wrIndex), .wrRe(wrRe), .wrIm(wrIm),
    .start(start), .busy(busy), .done(done), .rdRow(rdRow), .rdCol(rdCol),
    .rdRe(rdRe), .rdIm(rdIm)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    int row;
    int col;
    longint re;
    longint im;
    string tag;
  } exp_t;
  exp_t expQ[$];

  int sRe [ROWS][NCOL];
  int sIm [ROWS][NCOL];

  logic reqValid = 1'b0;
  logic latQ = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: one-cycle read latency (R5)
  always @(posedge clk) latQ <= reqValid;

  always @(negedge clk) begin
    if (latQ && expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(longint'(rdRe) == e.re, e.tag, $sformatf("R5 re(%0d,%0d)", e.row, e.col),
            longint'(rdRe), e.re);
      check(longint'(rdIm) == e.im, e.tag, $sformatf("R5 im(%0d,%0d)", e.row, e.col),
            longint'(rdIm), e.im);
    end
  end

  task automatic writeSample(input int idx, input int re, input int im);
    @(negedge clk);
    wrEn    = 1'b1;
    wrIndex = IW'(idx);
    wrRe    = SW'(re);
    wrIm    = SW'(im);
  endtask

  task automatic loadMatrix(input int mode);
    int seed;
    seed = 7;
    for (int r = 0; r < ROWS; r++) begin
      for (int k = 0; k < NCOL; k++) begin
        case (mode)
          0: begin sRe[r][k] = r * 16 + k - 50; sIm[r][k] = k - 3 * r; end
          1: begin
               sRe[r][k] = ((r + k) % 2 == 1) ? 32767 : -32768;
               sIm[r][k] = ((r * k) % 3 == 0) ? -32768 : 32767;
             end
          default: begin
               seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
               sRe[r][k] = (seed >>> 8) % 65536 - 32768;
               seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
               sIm[r][k] = (seed >>> 8) % 65536 - 32768;
             end
        endcase
      end
    end
    // row-major linear index, increasing order (R2)
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < NCOL; k++)
        writeSample(r * NCOL + k, sRe[r][k], sIm[r][k]);
    if (mode == 0) begin
      writeSample(TOTAL + 5, 12345, -23456);
      writeSample(TOTAL + ROWS - 1, -1000, 999);
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runEngine(input bit poke);
    int n;
    int extra;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after start", longint'(busy), 1);
    n = 0;
    while (n < TRI * NCOL + 50) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke) start = (n == 50);
      if (done) break;
    end
    start = 1'b0;
    check(n == TRI * NCOL + 1, poke ? "R8" : "R6", "cycles to done", n, TRI * NCOL + 1);
    check(busy == 1'b1, "R7", "busy during done", longint'(busy), 1);
    extra = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, poke ? "R8" : "R7", "extra done pulses", extra, 0);
    check(busy == 1'b0, "R7", "busy after done", longint'(busy), 0);
  endtask

  task automatic readAll(input string runTag);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < ROWS; c++) begin
        exp_t e;
        longint er, ei;
        er = 0;
        ei = 0;
        for (int k = 0; k < NCOL; k++) begin
          er += longint'(sRe[r][k]) * longint'(sRe[c][k]) + longint'(sIm[r][k]) * longint'(sIm[c][k]);
          ei += longint'(sIm[r][k]) * longint'(sRe[c][k]) - longint'(sRe[r][k]) * longint'(sIm[c][k]);
        end
        e.row = r;
        e.col = c;
        e.re  = er;
        e.im  = ei;
        if (r == c)      e.tag = {"R9/R3 ", runTag};
        else if (r > c)  e.tag = {"R3 ", runTag};
        else             e.tag = {"R4 ", runTag};
        @(negedge clk);
        rdRow = RW'(r);
        rdCol = RW'(c);
        reqValid = 1'b1;
        expQ.push_back(e);
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5", "pending reads", expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R6: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", longint'(busy), 0);
    check(done == 1'b0, "R1", "done in reset", longint'(done), 0);
    check(rdRe == '0, "R1", "rdRe in reset", longint'(rdRe), 0);
    check(rdIm == '0, "R1", "rdIm in reset", longint'(rdIm), 0);
    rstN = 1'b1;

    // ramp data plus out-of-range writes that must be dropped (R2)
    loadMatrix(0);
    runEngine(1'b0);
    readAll("R2 ramp");

    // full-scale data: widest sums (R3)
    loadMatrix(1);
    runEngine(1'b0);
    readAll("R3 fullscale R10");

    // pseudo-random data, second start during the run (R8, R10)
    loadMatrix(2);
    runEngine(1'b1);
    readAll("R10 random");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule